// File: doc/BRIEF.md
# Single-Cycle Load/Store Processor Core

This block is a compact processor that completes one instruction on every rising clock edge. It handles eight operations on 32-bit words: load, store, add, subtract, bitwise AND, bitwise OR, signed set-less-than, and branch-if-equal. The block holds the program counter, an instruction memory and a data memory as internal word arrays, a 32-entry register file, the sign extender, the branch-target adder, the opcode decoder and the ALU with its operation selector. There are no exceptions, no jumps and no pipeline.

Software reaches the core through a preload port only. While reset is held low, the port fills the instruction memory, or the data memory when a select bit is set. After reset is released, the core runs from address zero. A combinational debug port returns the contents of any register.

The opcode decoder turns the 6-bit opcode into seven single-bit control lines and a 2-bit ALU class. A branch is taken when the branch line and the ALU zero flag are both high.

Top module: `sc_core`

## Requirements
- R1: While `rst_n` is low, the PC is held at 0 and every register reads 0 on the debug port.
- R2: R-type instructions use opcode 0, rs in [25:21], rt in [20:16], rd in [15:11] and funct in [5:0]. In one cycle they write rd with rs+rt (funct 32), rs-rt (funct 34), rs AND rt (funct 36) or rs OR rt (funct 37). Bits [10:6] have no effect.
- R3: R-type funct 42 writes 1 to rd when rs is less than rt as signed two's-complement numbers, and writes 0 otherwise.
- R4: Opcode 35 loads the data word at byte address rs + sign-extend(instr[15:0]) into rt. The word index is address bits [DAW+1:2].
- R5: Opcode 43 stores rt at byte address rs + sign-extend(instr[15:0]) and changes no register.
- R6: Opcode 4 compares rs and rt. When they are equal, the next PC is PC+4+(sign-extend(instr[15:0])<<2); otherwise it is PC+4.
- R7: Register 0 always reads 0, and writes to it are discarded.
- R8: Any opcode other than 0, 4, 35 and 43 changes no register, no data word and no branch path. The PC simply advances by 4.
- R9: A cycle with `pre_en` high writes `pre_data` into word `pre_addr`. The target is the data memory when `pre_dmem` is 1 and the instruction memory when it is 0.
- R10: `dbg_data` shows register `dbg_idx` combinationally, with the last completed write visible.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state updates on the rising edge |
| rst_n | input | 1 | Active-low reset; holds the PC at 0 and clears the registers |
| pre_en | input | 1 | Preload write strobe |
| pre_dmem | input | 1 | Preload target: 1 selects the data memory, 0 the instruction memory |
| pre_addr | input | PAW | Preload word index |
| pre_data | input | 32 | Preload word |
| dbg_idx | input | 5 | Register index for the debug read |
| dbg_data | output | 32 | Contents of register `dbg_idx` |

## Verification
The hardest situation to reach is a state that only the ports can expose. Registers start at zero and no instruction loads an immediate, so every operand has to enter through a load from preloaded data. Branch outcomes and skipped stores are visible only through registers written later. Each program therefore ends with loads that read back the memory words an unknown opcode might have touched. Branch programs place marker adds inside skipped and fall-through regions, so the path taken shows up in the register values. The ALU sweep runs every pair from a set of edge-value operands, including sign-bit and all-ones words, through a fresh reset and preload each time.

// File: rtl/sc_pkg.sv
`timescale 1ns/1ps
package sc_pkg;
    localparam int unsigned XLEN      = 32;
    localparam int unsigned REG_IDX_W = 5;
    localparam int unsigned NREG      = 1 << REG_IDX_W;

    localparam logic [5:0] OPC_RTYPE = 6'd0;
    localparam logic [5:0] OPC_BEQ   = 6'd4;
    localparam logic [5:0] OPC_LW    = 6'd35;
    localparam logic [5:0] OPC_SW    = 6'd43;

    localparam logic [5:0] FN_ADD = 6'd32;
    localparam logic [5:0] FN_SUB = 6'd34;
    localparam logic [5:0] FN_AND = 6'd36;
    localparam logic [5:0] FN_OR  = 6'd37;
    localparam logic [5:0] FN_SLT = 6'd42;

    typedef enum logic [1:0] {
        CLS_ADD   = 2'b00,
        CLS_SUB   = 2'b01,
        CLS_FUNCT = 2'b10
    } alu_cls_e;

    typedef enum logic [2:0] {
        OP_AND, OP_OR, OP_ADD, OP_SUB, OP_SLT, OP_NONE
    } alu_op_e;

    typedef struct packed {
        logic     dst_rd;
        logic     src_imm;
        logic     wb_mem;
        logic     reg_we;
        logic     mem_rd;
        logic     mem_we;
        logic     branch;
        alu_cls_e cls;
    } ctl_t;
endpackage

// File: rtl/sc_decode.sv
`timescale 1ns/1ps
module sc_decode
    import sc_pkg::*;
(
    input  logic [5:0] opcode,
    output ctl_t       ctl
);
    always_comb begin
        ctl     = '0;
        ctl.cls = CLS_ADD;
        case (opcode)
            OPC_RTYPE: begin
                ctl.dst_rd = 1'b1;
                ctl.reg_we = 1'b1;
                ctl.cls    = CLS_FUNCT;
            end
            OPC_LW: begin
                ctl.src_imm = 1'b1;
                ctl.wb_mem  = 1'b1;
                ctl.reg_we  = 1'b1;
                ctl.mem_rd  = 1'b1;
            end
            OPC_SW: begin
                ctl.src_imm = 1'b1;
                ctl.mem_we  = 1'b1;
            end
            OPC_BEQ: begin
                ctl.branch = 1'b1;
                ctl.cls    = CLS_SUB;
            end
            default: ctl = ctl;
        endcase
    end
endmodule

// File: rtl/sc_alu.sv
`timescale 1ns/1ps
module sc_alu
    import sc_pkg::*;
#(
    parameter int unsigned W = XLEN
) (
    input  alu_cls_e     cls,
    input  logic [5:0]   funct,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] y,
    output logic         zero
);
    alu_op_e op;

    always_comb begin
        case (cls)
            CLS_ADD: op = OP_ADD;
            CLS_SUB: op = OP_SUB;
            CLS_FUNCT: begin
                case (funct)
                    FN_ADD:  op = OP_ADD;
                    FN_SUB:  op = OP_SUB;
                    FN_AND:  op = OP_AND;
                    FN_OR:   op = OP_OR;
                    FN_SLT:  op = OP_SLT;
                    default: op = OP_NONE;
                endcase
            end
            default: op = OP_NONE;
        endcase
    end

    always_comb begin
        case (op)
            OP_AND:  y = a & b;
            OP_OR:   y = a | b;
            OP_ADD:  y = a + b;
            OP_SUB:  y = a - b;
            OP_SLT:  y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
            default: y = '0;
        endcase
    end

    assign zero = (y == '0);
endmodule

// File: rtl/sc_regfile.sv
`timescale 1ns/1ps
module sc_regfile
    import sc_pkg::*;
#(
    parameter int unsigned W  = XLEN,
    parameter int unsigned AW = REG_IDX_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] ra1,
    input  logic [AW-1:0] ra2,
    input  logic [AW-1:0] ra3,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [W-1:0]  wd,
    output logic [W-1:0]  rd1,
    output logic [W-1:0]  rd2,
    output logic [W-1:0]  rd3
);
    localparam int unsigned N = 1 << AW;

    logic [W-1:0] regs_q [N];
    logic [W-1:0] regs_d [N];

    always_comb begin
        regs_d = regs_q;
        if (we && (wa != '0)) begin
            regs_d[wa] = wd;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N; i++) begin
                regs_q[i] <= '0;
            end
        end else begin
            regs_q <= regs_d;
        end
    end

    assign rd1 = (ra1 == '0) ? '0 : regs_q[ra1];
    assign rd2 = (ra2 == '0) ? '0 : regs_q[ra2];
    assign rd3 = (ra3 == '0) ? '0 : regs_q[ra3];
endmodule

// File: rtl/sc_core.sv
`timescale 1ns/1ps
module sc_core
    import sc_pkg::*;
#(
    parameter int unsigned IMEM_WORDS = 64,
    parameter int unsigned DMEM_WORDS = 64,
    localparam int unsigned IAW = $clog2(IMEM_WORDS),
    localparam int unsigned DAW = $clog2(DMEM_WORDS),
    localparam int unsigned PAW = (IAW > DAW) ? IAW : DAW
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 pre_en,
    input  logic                 pre_dmem,
    input  logic [PAW-1:0]       pre_addr,
    input  logic [XLEN-1:0]      pre_data,
    input  logic [REG_IDX_W-1:0] dbg_idx,
    output logic [XLEN-1:0]      dbg_data
);
    typedef struct packed {
        logic [XLEN-1:0] pc;
    } core_st_t;

    core_st_t st_d, st_q;
    logic [XLEN-1:0] pc_q;

    logic [XLEN-1:0] imem_q [IMEM_WORDS];
    logic [XLEN-1:0] imem_d [IMEM_WORDS];
    logic [XLEN-1:0] dmem_q [DMEM_WORDS];
    logic [XLEN-1:0] dmem_d [DMEM_WORDS];

    logic [XLEN-1:0]      instr;
    logic [5:0]           opcode;
    logic [REG_IDX_W-1:0] rs_idx, rt_idx, rd_idx, wr_idx;
    logic [XLEN-1:0]      imm_ext;
    logic [XLEN-1:0]      rs_val, rt_val, alu_b, alu_y, mem_rdata, wb_val;
    logic                 alu_zero;
    logic                 reg_we, mem_we, br_line;
    logic [DAW-1:0]       didx;
    ctl_t                 ctl;

    assign pc_q    = st_q.pc;
    assign instr   = imem_q[pc_q[IAW+1:2]];
    assign opcode  = instr[31:26];
    assign rs_idx  = instr[25:21];
    assign rt_idx  = instr[20:16];
    assign rd_idx  = instr[15:11];
    assign imm_ext = {{(XLEN-16){instr[15]}}, instr[15:0]};

    sc_decode u_dec (
        .opcode (opcode),
        .ctl    (ctl)
    );

    assign reg_we  = ctl.reg_we;
    assign mem_we  = ctl.mem_we;
    assign br_line = ctl.branch;
    assign wr_idx  = ctl.dst_rd ? rd_idx : rt_idx;
    assign alu_b   = ctl.src_imm ? imm_ext : rt_val;

    sc_alu #(.W(XLEN)) u_alu (
        .cls   (ctl.cls),
        .funct (instr[5:0]),
        .a     (rs_val),
        .b     (alu_b),
        .y     (alu_y),
        .zero  (alu_zero)
    );

    assign didx      = alu_y[DAW+1:2];
    assign mem_rdata = ctl.mem_rd ? dmem_q[didx] : '0;
    assign wb_val    = ctl.wb_mem ? mem_rdata : alu_y;

    sc_regfile #(.W(XLEN), .AW(REG_IDX_W)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .ra1   (rs_idx),
        .ra2   (rt_idx),
        .ra3   (dbg_idx),
        .we    (reg_we),
        .wa    (wr_idx),
        .wd    (wb_val),
        .rd1   (rs_val),
        .rd2   (rt_val),
        .rd3   (dbg_data)
    );

    always_comb begin
        logic [XLEN-1:0] seq_pc;
        seq_pc  = pc_q + XLEN'(4);
        st_d.pc = (br_line && alu_zero) ? (seq_pc + {imm_ext[XLEN-3:0], 2'b00}) : seq_pc;

        imem_d = imem_q;
        dmem_d = dmem_q;
        if (rst_n && mem_we) begin
            dmem_d[didx] = rt_val;
        end
        if (pre_en) begin
            if (pre_dmem) begin
                dmem_d[pre_addr[DAW-1:0]] = pre_data;
            end else begin
                imem_d[pre_addr[IAW-1:0]] = pre_data;
            end
        end
    end

    always_ff @(posedge clk) begin
        imem_q <= imem_d;
        dmem_q <= dmem_d;
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end
endmodule

// File: rtl/sc_core_chk.sv
`timescale 1ns/1ps
module sc_core_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] pc_q,
    input logic [5:0]  opcode,
    input logic [15:0] imm,
    input logic        reg_we,
    input logic        mem_we,
    input logic        br_line,
    input logic        alu_zero,
    input logic [4:0]  dbg_idx,
    input logic [31:0] dbg_data
);
    // R1: reset holds the PC at zero
    a_r1_pc_held: assert property (@(posedge clk) !rst_n |=> pc_q == 32'd0);

    // R6: a taken branch jumps relative to PC+4
    a_r6_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (br_line && alu_zero) |=> pc_q == $past(pc_q) + 32'd4 + {{14{$past(imm[15])}}, $past(imm), 2'b00});

    // R6: otherwise the PC advances by one word
    a_r6_seq: assert property (@(posedge clk) disable iff (!rst_n)
        !(br_line && alu_zero) |=> pc_q == $past(pc_q) + 32'd4);

    // R5: a store never writes a register
    a_r5_store_no_wb: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> !reg_we);

    // R8: unknown opcodes touch nothing
    a_r8_unknown_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !(opcode inside {6'd0, 6'd4, 6'd35, 6'd43}) |-> (!reg_we && !mem_we && !br_line));

    // R7: register 0 reads zero
    a_r7_zero_reg: assert property (@(posedge clk) disable iff (!rst_n)
        dbg_idx == 5'd0 |-> dbg_data == 32'd0);
endmodule

bind sc_core sc_core_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pc_q     (pc_q),
    .opcode   (opcode),
    .imm      (instr[15:0]),
    .reg_we   (reg_we),
    .mem_we   (mem_we),
    .br_line  (br_line),
    .alu_zero (alu_zero),
    .dbg_idx  (dbg_idx),
    .dbg_data (dbg_data)
);

// File: tb/test_sc_core.sv
`timescale 1ns/1ps
module test_sc_core;
    localparam int WORDS = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        pre_en = 1'b0;
    logic        pre_dmem = 1'b0;
    logic [5:0]  pre_addr = '0;
    logic [31:0] pre_data = '0;
    logic [4:0]  dbg_idx = '0;
    logic [31:0] dbg_data;

    int n_cmp = 0;
    int n_bad = 0;
    logic [31:0] prog [WORDS];

    always #2.5 clk = ~clk;

    sc_core #(.IMEM_WORDS(WORDS), .DMEM_WORDS(WORDS)) i_sc_core (
        .clk(clk), .rst_n(rst_n), .pre_en(pre_en), .pre_dmem(pre_dmem),
        .pre_addr(pre_addr), .pre_data(pre_data), .dbg_idx(dbg_idx), .dbg_data(dbg_data)
    );

    function automatic logic [31:0] rtype(int rs, int rt, int rd, int fn, int sh);
        return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'(sh), 6'(fn)};
    endfunction

    function automatic logic [31:0] itype(int op, int rs, int rt, int imm);
        return {6'(op), 5'(rs), 5'(rt), 16'(imm)};
    endfunction

    task automatic check(string req, logic [31:0] got, logic [31:0] exp);
        n_cmp++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic put(bit to_d, int addr, logic [31:0] data);
        @(negedge clk);
        pre_en = 1'b1; pre_dmem = to_d; pre_addr = 6'(addr); pre_data = data;
        @(posedge clk);
        #1 pre_en = 1'b0;
    endtask

    // R9: preload the program image while reset holds the core
    task automatic load_prog();
        @(negedge clk) rst_n = 1'b0;
        for (int i = 0; i < WORDS; i++) put(1'b0, i, prog[i]);
    endtask

    task automatic run(int n);
        @(negedge clk) rst_n = 1'b1;
        repeat (n) @(posedge clk);
        #1;
    endtask

    // R10: combinational debug read
    task automatic rd(int idx, output logic [31:0] v);
        dbg_idx = 5'(idx);
        #0.2 v = dbg_data;
    endtask

    task automatic clear_prog();
        for (int i = 0; i < WORDS; i++) prog[i] = 32'd0;
    endtask

    initial begin
        #(100000 * 5);
        n_cmp++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic [31:0] vals [8];
        vals = '{32'd0, 32'd1, 32'd7, 32'hFFFF_FFFF, 32'h8000_0000,
                 32'h7FFF_FFFF, 32'h1234_5678, 32'hF0F0_F0F0};

        repeat (3) @(posedge clk);
        #1;
        for (int r = 0; r < 32; r++) begin
            rd(r, v);
            check("R1 reset regs", v, 32'd0);
        end

        // ALU sweep program (R2, R3, R5, R7)
        clear_prog();
        prog[0]  = itype(35, 0, 1, 0);
        prog[1]  = itype(35, 0, 2, 4);
        prog[2]  = rtype(1, 2, 3, 32, 5);
        prog[3]  = rtype(1, 2, 4, 34, 0);
        prog[4]  = rtype(1, 2, 5, 36, 0);
        prog[5]  = rtype(1, 2, 6, 37, 0);
        prog[6]  = rtype(1, 2, 7, 42, 0);
        prog[7]  = rtype(2, 1, 8, 42, 0);
        prog[8]  = itype(43, 0, 3, 8);
        prog[9]  = itype(35, 0, 9, 8);
        prog[10] = rtype(1, 2, 0, 32, 0);
        for (int ia = 0; ia < 8; ia++) begin
            for (int ib = 0; ib < 8; ib++) begin
                logic [31:0] a, b;
                a = vals[ia]; b = vals[ib];
                load_prog();
                put(1'b1, 0, a);
                put(1'b1, 1, b);
                run(11);
                rd(3, v); check("R2 add shamt ignored", v, a + b);
                rd(4, v); check("R2 sub", v, a - b);
                rd(5, v); check("R2 and", v, a & b);
                rd(6, v); check("R2 or", v, a | b);
                rd(7, v); check("R3 slt a<b", v, {31'd0, $signed(a) < $signed(b)});
                rd(8, v); check("R3 slt b<a", v, {31'd0, $signed(b) < $signed(a)});
                rd(9, v); check("R5 store then load", v, a + b);
                rd(0, v); check("R7 r0 stays zero", v, 32'd0);
            end
        end

        // Branch program (R6)
        clear_prog();
        prog[0]  = itype(35, 0, 1, 0);
        prog[1]  = itype(35, 0, 2, 4);
        prog[2]  = itype(35, 0, 3, 8);
        prog[3]  = itype(4, 1, 2, 2);
        prog[4]  = rtype(1, 1, 10, 32, 0);
        prog[5]  = rtype(1, 1, 11, 32, 0);
        prog[6]  = itype(4, 1, 3, 1);
        prog[7]  = rtype(1, 3, 12, 32, 0);
        prog[8]  = itype(4, 0, 0, 1);
        prog[9]  = rtype(1, 1, 13, 32, 0);
        prog[10] = rtype(3, 3, 14, 32, 0);
        load_prog();
        put(1'b1, 0, 32'd5);
        put(1'b1, 1, 32'd5);
        put(1'b1, 2, 32'd7);
        run(8);
        rd(10, v); check("R6 taken skips first", v, 32'd0);
        rd(11, v); check("R6 taken skips second", v, 32'd0);
        rd(12, v); check("R6 not-taken falls through", v, 32'd12);
        rd(13, v); check("R6 r0==r0 taken", v, 32'd0);
        rd(14, v); check("R6 target reached", v, 32'd14);

        // Unknown opcodes and negative offsets (R8, R4, R5)
        clear_prog();
        prog[0] = itype(35, 0, 1, 0);
        prog[1] = itype(35, 0, 2, 4);
        prog[2] = itype(8, 0, 2, 5);
        prog[3] = itype(63, 1, 1, 16);
        prog[4] = itype(40, 0, 1, 8);
        prog[5] = itype(35, 0, 15, 12);
        prog[6] = itype(35, 15, 16, -8);
        prog[7] = itype(43, 15, 2, -4);
        prog[8] = itype(35, 0, 17, 12);
        load_prog();
        put(1'b1, 0, 32'hCAFE_0001);
        put(1'b1, 1, 32'h0000_0BEE);
        put(1'b1, 2, 32'h5A5A_5A5A);
        put(1'b1, 3, 32'd16);
        run(9);
        rd(1, v);  check("R8 unknown op kept r1", v, 32'hCAFE_0001);
        rd(2, v);  check("R8 unknown op kept r2", v, 32'h0000_0BEE);
        rd(15, v); check("R4 load base", v, 32'd16);
        rd(16, v); check("R4 negative offset load / R8 no store", v, 32'h5A5A_5A5A);
        rd(17, v); check("R5 negative offset store", v, 32'h0000_0BEE);

        // R1: reset clears registers again
        @(negedge clk) rst_n = 1'b0;
        @(posedge clk);
        #1;
        for (int r = 0; r < 32; r++) begin
            rd(r, v);
            check("R1 re-reset regs", v, 32'd0);
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule